// File: doc/BRIEF.md
# Audio Sample Buffer with DMA Request Control

This block buffers sound words between a producer and a sample consumer that drains at the playback rate. Words arrive either from a host write port, or, when DMA mode is selected, through a single-cycle write strobe that counts only while the acknowledge input is at its active level. The consumer pulls words through a valid/ready port. That port offers data only while playback is running and not paused.

The usable depth is chosen at run time from the parameter `MAX_DEPTH`. A two-bit select halves the depth once or twice. A bus-width bit halves it once more, because a wide bus carries one word per entry. The fourth select code removes the storage, and the host port then connects straight to the consumer. Three fill flags report empty, more than half and full. The polarity of these flags, of the DMA request and of the acknowledge input is configurable. The DMA request has hysteresis: it rises on the play command, falls once the buffer is full, and rises again only after the fill has fallen to half.

One instance serves one audio channel. In stereo mode the host channel-select bit steers each write, and an instance accepts only writes addressed to its own side, set by the `CHAN_SIDE` parameter. Back-pressure rules on the host port:
- `wr_ready` reports whether a beat would be stored in the current cycle.
- A beat offered while `wr_ready` is low is dropped. It is not held.
- If the drop was caused by a full buffer, the overrun bit is set.

On the consumer port, a word leaves on each cycle where `rd_valid` and `rd_ready` are both high.

Top module: `audio_sample_buffer`

## Requirements
- R1: After reset, `st_empty` is 1, `st_half`, `st_full`, `st_overrun`, `dma_req`, `playing` and `rd_valid` are 0, and the polarity configuration is active-high.
- R2: The usable depth is `MAX_DEPTH >> (cfg_depth_sel + cfg_word_bus)` for select codes 0, 1 and 2. Exactly that many writes fill the buffer, and `wr_ready` is 0 while it is full.
- R3: A write attempted while the buffer is full is discarded and sets the sticky `st_overrun`. The discarded word never appears at `rd_data`.
- R4: After `cmd_play`, playback waits until the buffer holds a word. `playing` and `rd_valid` rise on the second clock edge after the first write is stored.
- R5: Words leave in write order. This holds across pointer wrap at the selected depth.
- R6: The raw flags are defined as follows, with `cfg_flag_low = 1` inverting all three:
  - empty: fill equals 0;
  - half: fill is greater than depth/2;
  - full: fill equals depth.
- R7: With `cfg_dma_en`, the DMA request behaves as follows, with `cfg_req_low = 1` inverting the pin:
  - it is active one edge after `cmd_play`;
  - it stays active until the fill reaches depth, then drops one edge later;
  - it stays inactive until the fill is at or below depth/2, and is active again one edge after that.
- R8: With `cfg_dma_en`, a word is stored on `iow_strobe` only while `dma_ack` is at its active level, which is low when `cfg_ack_high = 0` and high when it is 1. The host port is ignored in this mode.
- R9: `cmd_stop` empties the buffer and clears `playing`, `paused`, `st_overrun` and the DMA request. A write in the same cycle is discarded without setting `st_overrun`.
- R10: While paused, `rd_valid` is 0. After `cmd_resume`, reading continues with the next unread word.
- R11: With `cfg_stereo = 1`, a host write is accepted only when `wr_chan` equals `CHAN_SIDE`, where 1 means right and 0 means left. With `cfg_stereo = 0`, `wr_chan` is ignored.
- R12: During playback, after `cfg_timeout` consecutive clock edges with an empty buffer, no write and no pause, `playing` returns to 0.
- R13: With `cfg_depth_sel = 3`:
  - `rd_valid` follows `wr_valid`, `rd_data` follows `wr_data`, and `wr_ready` follows `rd_ready`;
  - nothing is stored, and all three flags sit at their inactive level.
- R14: A store and a read in the same cycle leave the fill unchanged while the buffer is not full. When the buffer is full, the store is dropped even if a read occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_depth_sel | input | 2 | Depth select; 0 to 2 halve the depth that many times, 3 bypasses the storage |
| cfg_word_bus | input | 1 | 1 selects the wide bus, which halves the depth once more |
| cfg_stereo | input | 1 | 1 enables steering of host writes by `wr_chan` |
| cfg_flag_low | input | 1 | 1 makes the three fill flags active-low |
| cfg_req_low | input | 1 | 1 makes `dma_req` active-low |
| cfg_ack_high | input | 1 | 1 makes `dma_ack` active-high (default active-low) |
| cfg_dma_en | input | 1 | 1 takes words from the strobe port instead of the host port |
| cfg_timeout | input | TIMEOUT_W | Number of empty edges that ends playback; 0 disables the timeout |
| cmd_play | input | 1 | Play command pulse |
| cmd_stop | input | 1 | Stop and clear pulse |
| cmd_pause | input | 1 | Pause pulse |
| cmd_resume | input | 1 | Resume pulse |
| wr_valid | input | 1 | Host beat valid |
| wr_ready | output | 1 | Host beat would be stored this cycle |
| wr_chan | input | 1 | Host channel select (1 right, 0 left) |
| wr_data | input | DATA_W | Host word |
| dma_ack | input | 1 | DMA acknowledge |
| iow_strobe | input | 1 | DMA write strobe, one cycle per word |
| iow_data | input | DATA_W | DMA word |
| rd_valid | output | 1 | Consumer word valid |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | DATA_W | Consumer word |
| st_empty | output | 1 | Empty flag |
| st_half | output | 1 | More-than-half flag |
| st_full | output | 1 | Full flag |
| st_overrun | output | 1 | Sticky flag: a write was attempted while full |
| dma_req | output | 1 | DMA transfer request |
| playing | output | 1 | Playback running |
| paused | output | 1 | Playback paused |

## Verification
The collision that matters most is a store and a read landing in the same cycle. The bench provokes it by raising `wr_valid` and `rd_ready` on one edge, first at three-quarters fill and then at full fill. At three-quarters fill, the flags must show an unchanged fill. At full fill, the flags must show one word fewer and `st_overrun` must be set. The drain that follows must return the survivors in order, with the dropped word absent. A second collision pairs a stop with a write: the flags must show an empty buffer and `st_overrun` must stay clear.

// File: rtl/asb_pkg.sv
package asb_pkg;
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_ARMED = 2'd1,
    PS_RUN   = 2'd2
  } play_state_t;

  localparam logic [1:0] SEL_BYPASS = 2'd3;
endpackage

// File: rtl/asb_store.sv
module asb_store #(
  parameter int DATA_W    = 16,
  parameter int MAX_DEPTH = 128,
  localparam int AW = $clog2(MAX_DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [CW-1:0]     depth,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem [MAX_DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] last;

  assign last     = depth - CW'(1);
  assign pop_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clear) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == last[AW-1:0]) ? '0 : wptr + AW'(1);
      if (pop)  rptr <= (rptr == last[AW-1:0]) ? '0 : rptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R9: a stop leaves the store empty on the next edge
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));
endmodule

// File: rtl/asb_flags.sv
module asb_flags #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] depth,
  input  logic          bypass,
  input  logic          flag_low,
  output logic          st_empty,
  output logic          st_half,
  output logic          st_full
);
  logic raw_empty, raw_half, raw_full;

  always_comb begin
    raw_empty = !bypass && (count == '0);
    raw_half  = !bypass && (count > (depth >> 1));
    raw_full  = !bypass && (count == depth);
  end

  assign st_empty = raw_empty ^ flag_low;
  assign st_half  = raw_half  ^ flag_low;
  assign st_full  = raw_full  ^ flag_low;
endmodule

// File: rtl/asb_dma.sv
module asb_dma #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          play,
  input  logic          stop,
  input  logic          active,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] depth,
  input  logic          req_low,
  output logic          dma_req
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      req_q <= 1'b0;
    else if (!enable || stop)        req_q <= 1'b0;
    else if (play)                   req_q <= 1'b1;
    else if (!active)                req_q <= 1'b0;
    else if (count == depth)         req_q <= 1'b0;
    else if (count <= (depth >> 1))  req_q <= 1'b1;
  end

  assign dma_req = req_q ^ req_low;

  // R7: the request only comes back on a play command or at half fill
  assert_req_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(play || (count <= (depth >> 1))));
endmodule

// File: rtl/asb_play.sv
module asb_play
  import asb_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          play,
  input  logic          stop,
  input  logic          pause,
  input  logic          resume,
  input  logic          count_zero,
  input  logic          push,
  input  logic [TW-1:0] limit,
  output logic          playing,
  output logic          paused,
  output logic          active,
  output logic          rd_en
);
  play_state_t state;
  logic [TW-1:0] tcnt, tcnt_n;

  assign tcnt_n  = tcnt + TW'(1);
  assign playing = (state == PS_RUN);
  assign active  = (state != PS_IDLE);
  assign rd_en   = playing && !paused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PS_IDLE;
      paused <= 1'b0;
      tcnt   <= '0;
    end else if (stop) begin
      state  <= PS_IDLE;
      paused <= 1'b0;
      tcnt   <= '0;
    end else begin
      if (pause && active) paused <= 1'b1;
      else if (resume)     paused <= 1'b0;
      case (state)
        PS_IDLE:  if (play) state <= PS_ARMED;
        PS_ARMED: if (!count_zero) state <= PS_RUN;
        PS_RUN: begin
          if (count_zero && !push && !paused) begin
            if (limit != '0 && tcnt_n == limit) begin
              state <= PS_IDLE;
              tcnt  <= '0;
            end else begin
              tcnt <= tcnt_n;
            end
          end else begin
            tcnt <= '0;
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  // R4: playback never starts on an empty store
  assert_start_after_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(playing) |-> $past(!count_zero));
  // R12: the timeout cannot end playback while words remain
  assert_timeout_only_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && !count_zero && !stop) |=> playing);
endmodule

// File: rtl/audio_sample_buffer.sv
module audio_sample_buffer
  import asb_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_DEPTH = 128,
  parameter int TIMEOUT_W = 16,
  parameter bit CHAN_SIDE = 1'b0,
  localparam int AW = $clog2(MAX_DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_depth_sel,
  input  logic                 cfg_word_bus,
  input  logic                 cfg_stereo,
  input  logic                 cfg_flag_low,
  input  logic                 cfg_req_low,
  input  logic                 cfg_ack_high,
  input  logic                 cfg_dma_en,
  input  logic [TIMEOUT_W-1:0] cfg_timeout,
  input  logic                 cmd_play,
  input  logic                 cmd_stop,
  input  logic                 cmd_pause,
  input  logic                 cmd_resume,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic                 wr_chan,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 dma_ack,
  input  logic                 iow_strobe,
  input  logic [DATA_W-1:0]    iow_data,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 st_empty,
  output logic                 st_half,
  output logic                 st_full,
  output logic                 st_overrun,
  output logic                 dma_req,
  output logic                 playing,
  output logic                 paused
);
  logic [CW-1:0] depth, count;
  logic [DATA_W-1:0] pop_data, wdata;
  logic bypass, host_sel, ack_active, dma_fire, host_fire;
  logic wr_attempt, space, push, pop, fifo_valid, rd_en, active;

  always_comb begin
    bypass     = (cfg_depth_sel == SEL_BYPASS);
    depth      = CW'(MAX_DEPTH) >> ({1'b0, cfg_depth_sel} + {2'b00, cfg_word_bus});
    host_sel   = !cfg_dma_en && (!cfg_stereo || (wr_chan == CHAN_SIDE));
    ack_active = cfg_ack_high ? dma_ack : !dma_ack;
    dma_fire   = cfg_dma_en && iow_strobe && ack_active;
    host_fire  = wr_valid && host_sel;
    wr_attempt = !bypass && !cmd_stop && (dma_fire || host_fire);
    space      = (count < depth);
    push       = wr_attempt && space;
    wdata      = cfg_dma_en ? iow_data : wr_data;
    fifo_valid = rd_en && (count != '0);
    pop        = !bypass && fifo_valid && rd_ready && !cmd_stop;
    rd_valid   = bypass ? host_fire : fifo_valid;
    rd_data    = bypass ? wr_data : pop_data;
    wr_ready   = bypass ? (host_sel && rd_ready) : (host_sel && space);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      st_overrun <= 1'b0;
    else if (cmd_stop)               st_overrun <= 1'b0;
    else if (wr_attempt && !space)   st_overrun <= 1'b1;
  end

  asb_store #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(cmd_stop), .depth(depth),
    .push(push), .push_data(wdata), .pop(pop), .pop_data(pop_data), .count(count)
  );

  asb_flags #(.CW(CW)) u_flags (
    .count(count), .depth(depth), .bypass(bypass), .flag_low(cfg_flag_low),
    .st_empty(st_empty), .st_half(st_half), .st_full(st_full)
  );

  asb_dma #(.CW(CW)) u_dma (
    .clk(clk), .rst_n(rst_n), .enable(cfg_dma_en && !bypass), .play(cmd_play),
    .stop(cmd_stop), .active(active), .count(count), .depth(depth),
    .req_low(cfg_req_low), .dma_req(dma_req)
  );

  asb_play #(.TW(TIMEOUT_W)) u_play (
    .clk(clk), .rst_n(rst_n), .play(cmd_play), .stop(cmd_stop), .pause(cmd_pause),
    .resume(cmd_resume), .count_zero(count == '0), .push(push), .limit(cfg_timeout),
    .playing(playing), .paused(paused), .active(active), .rd_en(rd_en)
  );

  // R3: overrun is only ever raised by a write that met a full store
  assert_overrun_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_overrun) |-> $past(count == depth));
  // R10: nothing leaves the store unless playback runs unpaused
  assert_pop_only_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (playing && !paused));
  // R8: with the acknowledge inactive the fill cannot grow
  assert_ack_gates_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dma_en && !ack_active) |=> (count <= $past(count)));
  // R2: a full store never advertises ready
  assert_full_blocks_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && (st_full != cfg_flag_low)) |-> !wr_ready);
endmodule

// File: tb/audio_sample_buffer_test.sv
module audio_sample_buffer_test;
  localparam int DW = 16;
  localparam int MD = 16;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_depth_sel = 2'd0;
  logic cfg_word_bus = 0, cfg_stereo = 0, cfg_flag_low = 0, cfg_req_low = 0;
  logic cfg_ack_high = 0, cfg_dma_en = 0;
  logic [TW-1:0] cfg_timeout = 8'd200;
  logic cmd_play = 0, cmd_stop = 0, cmd_pause = 0, cmd_resume = 0;
  logic wr_valid = 0, wr_chan = 0, dma_ack = 1, iow_strobe = 0, rd_ready = 0;
  logic [DW-1:0] wr_data = '0, iow_data = '0;
  logic wr_ready, rd_valid, st_empty, st_half, st_full, st_overrun, dma_req, playing, paused;
  logic [DW-1:0] rd_data;

  int ntests = 0;
  int nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  audio_sample_buffer #(.DATA_W(DW), .MAX_DEPTH(MD), .TIMEOUT_W(TW), .CHAN_SIDE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_depth_sel(cfg_depth_sel), .cfg_word_bus(cfg_word_bus),
    .cfg_stereo(cfg_stereo), .cfg_flag_low(cfg_flag_low), .cfg_req_low(cfg_req_low),
    .cfg_ack_high(cfg_ack_high), .cfg_dma_en(cfg_dma_en), .cfg_timeout(cfg_timeout),
    .cmd_play(cmd_play), .cmd_stop(cmd_stop), .cmd_pause(cmd_pause), .cmd_resume(cmd_resume),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_chan(wr_chan), .wr_data(wr_data),
    .dma_ack(dma_ack), .iow_strobe(iow_strobe), .iow_data(iow_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .st_empty(st_empty), .st_half(st_half), .st_full(st_full), .st_overrun(st_overrun),
    .dma_req(dma_req), .playing(playing), .paused(paused)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic push_host(input logic [DW-1:0] d);
    wr_valid = 1; wr_data = d; cyc(); wr_valid = 0;
  endtask

  task automatic push_iow(input logic [DW-1:0] d);
    iow_strobe = 1; iow_data = d; cyc(); iow_strobe = 0;
  endtask

  task automatic pop_one(input string what, input logic [DW-1:0] exp);
    chk({what, " rd_valid"}, rd_valid, 1);
    chk({what, " rd_data"}, rd_data, exp);
    rd_ready = 1; cyc(); rd_ready = 0;
  endtask

  task automatic do_play();   cmd_play = 1;   cyc(); cmd_play = 0;   endtask
  task automatic do_stop();   cmd_stop = 1;   cyc(); cmd_stop = 0;   endtask
  task automatic do_pause();  cmd_pause = 1;  cyc(); cmd_pause = 0;  endtask
  task automatic do_resume(); cmd_resume = 1; cyc(); cmd_resume = 0; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    ntests++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 empty", st_empty, 1);
    chk("R1 half", st_half, 0);
    chk("R1 full", st_full, 0);
    chk("R1 overrun", st_overrun, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 playing", playing, 0);
    chk("R1 rd_valid", rd_valid, 0);

    // R2 R3 R5 R6: sweep every stored depth code
    for (int k = 0; k < 6; k++) begin
      int d;
      cfg_depth_sel = 2'(k % 3);
      cfg_word_bus  = (k >= 3);
      d = MD >> ((k % 3) + (k >= 3 ? 1 : 0));
      do_stop();
      chk("R9 overrun cleared by stop", st_overrun, 0);
      for (int i = 0; i < d; i++) begin
        chk("R6 empty", st_empty, (i == 0));
        chk("R6 half", st_half, (i > d / 2));
        chk("R6 full", st_full, 0);
        chk("R2 ready", wr_ready, 1);
        push_host(16'(k * 256 + i));
      end
      chk("R2 full at depth", st_full, 1);
      chk("R6 half at depth", st_half, 1);
      chk("R2 ready low at full", wr_ready, 0);
      push_host(16'hDEAD);
      chk("R3 overrun set", st_overrun, 1);
      do_play();
      cyc();
      chk("R4 playing prefilled", playing, 1);
      for (int i = 0; i < d; i++) pop_one("R5 drain order", 16'(k * 256 + i));
      chk("R3 dropped word absent", st_empty, 1);
      chk("R3 rd_valid after drain", rd_valid, 0);
    end

    // R6 polarity
    do_stop();
    cfg_depth_sel = 2'd2; cfg_word_bus = 0;
    cfg_flag_low = 1;
    #1;
    chk("R6 low empty", st_empty, 0);
    chk("R6 low half", st_half, 1);
    chk("R6 low full", st_full, 1);
    cfg_flag_low = 0;

    // R4 start timing and R12 timeout (depth 4)
    cfg_timeout = 8'd5;
    do_play();
    chk("R4 armed not playing", playing, 0);
    push_host(16'h0111);
    chk("R4 one edge after write", playing, 0);
    chk("R4 rd_valid one edge after write", rd_valid, 0);
    cyc();
    chk("R4 playing two edges after write", playing, 1);
    pop_one("R4 first word", 16'h0111);
    repeat (4) cyc();
    chk("R12 still playing before limit", playing, 1);
    cyc();
    chk("R12 idle at limit", playing, 0);
    cfg_timeout = 8'd200;

    // R14 collisions, R5 wrap (depth 4)
    do_stop();
    push_host(16'h1); push_host(16'h2); push_host(16'h3);
    do_play(); cyc();
    wr_valid = 1; wr_data = 16'h4; rd_ready = 1;
    chk("R14 head word", rd_data, 16'h1);
    cyc(); wr_valid = 0; rd_ready = 0;
    chk("R14 fill unchanged full", st_full, 0);
    chk("R14 fill unchanged half", st_half, 1);
    push_host(16'h5);
    chk("R14 full after push", st_full, 1);
    wr_valid = 1; wr_data = 16'h6; rd_ready = 1;
    chk("R14 head at full", rd_data, 16'h2);
    cyc(); wr_valid = 0; rd_ready = 0;
    chk("R14 store dropped at full", st_full, 0);
    chk("R14 overrun at full collision", st_overrun, 1);
    pop_one("R5 wrap", 16'h3);
    pop_one("R5 wrap", 16'h4);
    pop_one("R5 wrap", 16'h5);
    chk("R14 dropped word absent", st_empty, 1);

    // R10 pause
    do_stop();
    push_host(16'h0A1); push_host(16'h0B2);
    do_play(); cyc();
    pop_one("R10 before pause", 16'h0A1);
    do_pause();
    chk("R10 paused valid", rd_valid, 0);
    chk("R10 paused flag", paused, 1);
    repeat (3) cyc();
    chk("R10 still paused", rd_valid, 0);
    do_resume();
    pop_one("R10 resumed word", 16'h0B2);

    // R9 stop wins over write
    push_host(16'h0C3);
    cmd_stop = 1; wr_valid = 1; wr_data = 16'h0D4;
    cyc(); cmd_stop = 0; wr_valid = 0;
    chk("R9 empty after stop", st_empty, 1);
    chk("R9 not playing", playing, 0);
    chk("R9 overrun clear", st_overrun, 0);

    // R11 stereo steering (instance is left side)
    cfg_stereo = 1; wr_chan = 1; wr_valid = 1; wr_data = 16'h0E5;
    #1 chk("R11 wrong side ready", wr_ready, 0);
    cyc(); wr_valid = 0;
    chk("R11 wrong side ignored", st_empty, 1);
    wr_chan = 0;
    push_host(16'h0E6);
    chk("R11 own side stored", st_empty, 0);
    do_stop();
    cfg_stereo = 0; wr_chan = 1;
    push_host(16'h0E7);
    chk("R11 mono ignores chan", st_empty, 0);
    wr_chan = 0;
    do_stop();

    // R7 DMA request hysteresis (depth 4, ack active low)
    cfg_dma_en = 1; dma_ack = 0;
    cyc();
    chk("R7 idle request", dma_req, 0);
    do_play();
    chk("R7 request after play", dma_req, 1);
    for (int i = 0; i < 4; i++) push_iow(16'(16'h200 + i));
    chk("R7 request held at fill edge", dma_req, 1);
    chk("R7 full", st_full, 1);
    cyc();
    chk("R7 request dropped after full", dma_req, 0);
    pop_one("R8 dma data", 16'h200);
    cyc();
    chk("R7 no request above half", dma_req, 0);
    pop_one("R8 dma data", 16'h201);
    chk("R7 request one edge later", dma_req, 0);
    cyc();
    chk("R7 request back at half", dma_req, 1);
    cfg_req_low = 1;
    #1 chk("R7 request polarity", dma_req, 0);
    cfg_req_low = 0;

    // R8 acknowledge gating and polarity
    do_stop();
    dma_ack = 1;
    push_iow(16'h300);
    chk("R8 inactive ack ignored", st_empty, 1);
    push_host(16'h301);
    chk("R8 host ignored in dma mode", st_empty, 1);
    dma_ack = 0;
    push_iow(16'h302);
    chk("R8 active-low ack stored", st_empty, 0);
    do_stop();
    cfg_ack_high = 1; dma_ack = 1;
    push_iow(16'h303);
    chk("R8 active-high ack stored", st_empty, 0);
    do_stop();
    cfg_dma_en = 0; cfg_ack_high = 0;

    // R13 bypass
    cfg_depth_sel = 2'd3;
    wr_valid = 1; wr_data = 16'h5A5A; rd_ready = 1;
    #1;
    chk("R13 valid passthrough", rd_valid, 1);
    chk("R13 data passthrough", rd_data, 16'h5A5A);
    chk("R13 ready passthrough", wr_ready, 1);
    chk("R13 empty inactive", st_empty, 0);
    rd_ready = 0;
    #1 chk("R13 ready follows consumer", wr_ready, 0);
    cyc(); wr_valid = 0;
    chk("R13 no overrun", st_overrun, 0);
    cfg_depth_sel = 2'd2;
    #1 chk("R13 nothing stored", st_empty, 1);

    finish_run();
  end
endmodule